// File: doc/BRIEF.md
# SMM Memory Window Decoder

This block sits on the request path of a memory controller and classifies each incoming transaction address against three protected system-management windows. The legacy window covers 0x000A_0000 to 0x000B_FFFF. The upper window covers 0xFEDA_0000 to 0xFEDB_FFFF and is folded back onto the legacy DRAM range. The segment window ends at the top of low memory.

For every request the block decides whether the access may reach the protected DRAM. A window hit that is not granted goes to the graphics port or to the downstream I/O link. Every other address is routed by the top of low memory.

A request is one `req_valid` pulse. The decision appears, registered, one clock later. A configuration-error output flags illegal enable settings, and no window is granted while such a setting is present.

Top module: `smm_window_decoder`

## Requirements
- R1: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and low otherwise. After reset, `rsp_valid`, `rsp_dest`, `rsp_dram_addr` and `cfg_err` are all zero.
- R2: With `cfg_glob_en`=1 and `cfg_high_en`=0 the legacy window is enabled. A granted access to it gets `rsp_dest`=0 (DRAM), and `rsp_dram_addr` equals the request address.
- R3: With `cfg_glob_en`=1 and `cfg_high_en`=1 the upper window is enabled and the legacy window is disabled. A granted upper-window access gets `rsp_dest`=0 and `rsp_dram_addr` = address − 0xFEDA_0000 + 0x000A_0000.
- R4: With `cfg_glob_en`=0 no window is granted, whatever the values of `cfg_high_en` and `cfg_seg_en`.
- R5: The segment window is [tolm − size, tolm). The size code in `cfg_seg_size` is 00=1 MiB, 01=2 MiB, 10=8 MiB and 11=reserved. The window is enabled when `cfg_glob_en` and `cfg_seg_en` are both 1, the size code is not reserved, and tolm ≥ size. A granted segment access goes to DRAM with an unchanged address.
- R6: A hit on an enabled window is granted only when the source is the CPU (`req_src`=00) and `smm_mode` or `cfg_open` is 1.
- R7: An access to 0x000A_0000–0x000B_FFFF that is not granted goes to the graphics port (`rsp_dest`=1) when `cfg_vga_en`=1, and otherwise to the I/O link (`rsp_dest`=2).
- R8: Requests from the graphics port (`req_src`=01) or from the I/O link (`req_src`=10 or 11) are never granted any window.
- R9: `cfg_err` is 1 one cycle after `cfg_open` and `cfg_close` are both 1, or after `cfg_seg_size`=11. While either condition holds, no window is granted.
- R10: An ungranted hit on the upper window, or on the enabled segment window, goes to the I/O link. Any other address below tolm goes to DRAM unchanged. Any other address at or above tolm goes to the I/O link.
- R11: `rsp_dram_addr` is zero whenever `rsp_dest` is not DRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_addr | input | ADDR_W (32) | Request bus address |
| req_src | input | 2 | Source: 00 CPU, 01 graphics port, 10/11 I/O link |
| smm_mode | input | 1 | Requester is in system-management mode |
| cfg_glob_en | input | 1 | Global window enable |
| cfg_high_en | input | 1 | Selects the upper window instead of the legacy one |
| cfg_seg_en | input | 1 | Segment window enable |
| cfg_seg_size | input | 2 | Segment size code |
| cfg_open | input | 1 | Opens windows to accesses outside SMM mode |
| cfg_close | input | 1 | Close bit, illegal together with open |
| cfg_vga_en | input | 1 | Legacy range belongs to the graphics port |
| tolm | input | ADDR_W (32) | Top of low memory |
| rsp_valid | output | 1 | Decision strobe |
| rsp_dest | output | 2 | Destination: 00 DRAM, 01 graphics port, 10 I/O link |
| rsp_dram_addr | output | ADDR_W (32) | DRAM address, zero if not DRAM |
| cfg_err | output | 1 | Illegal configuration |

## Verification
The checker assumes that the configuration inputs and `tolm` stay stable during the cycle in which a request is sampled. It also assumes that `req_valid` never stays high for two cycles back to back, because each transaction is one pulse. The bench follows both rules. It changes configuration only between transactions, and it drives each request as a single-cycle pulse away from the clock edge, followed by an idle cycle before the result is read.

// File: rtl/smm_dec_pkg.sv
package smm_dec_pkg;

   typedef enum logic [1:0] {
      DEST_DRAM = 2'd0,
      DEST_GFX  = 2'd1,
      DEST_IOL  = 2'd2
   } dest_e;

   localparam logic [1:0] SRC_CPU = 2'd0;

   localparam logic [31:0] LEGACY_LO = 32'h000A_0000;
   localparam logic [31:0] LEGACY_HI = 32'h000B_FFFF;
   localparam logic [31:0] UPPER_LO  = 32'hFEDA_0000;
   localparam logic [31:0] UPPER_HI  = 32'hFEDB_FFFF;

   localparam logic [1:0] SEG_CODE_RSVD = 2'b11;

endpackage

// File: rtl/smm_cfg_check.sv
module smm_cfg_check #(
   parameter int ADDR_W        = 32,
   parameter int SEG_UNIT_LOG2 = 20
) (
   input  logic              open_i,
   input  logic              close_i,
   input  logic [1:0]        size_code_i,
   output logic              illegal_o,
   output logic              size_ok_o,
   output logic [ADDR_W-1:0] seg_bytes_o
);
   import smm_dec_pkg::*;

   localparam int N_CODES = 3;
   localparam int SHIFT_W = $clog2(SEG_UNIT_LOG2 + 4);

   logic [N_CODES-1:0][SHIFT_W-1:0] shift_tbl;

   genvar gi;
   generate
      for (gi = 0; gi < N_CODES; gi++) begin : g_tbl
         if (gi == 2) begin : g_big
            assign shift_tbl[gi] = SHIFT_W'(SEG_UNIT_LOG2 + 3);
         end else begin : g_small
            assign shift_tbl[gi] = SHIFT_W'(SEG_UNIT_LOG2 + gi);
         end
      end
   endgenerate

   always_comb begin
      size_ok_o   = (size_code_i != SEG_CODE_RSVD);
      illegal_o   = (open_i & close_i) | ~size_ok_o;
      seg_bytes_o = '0;
      if (size_ok_o) begin
         seg_bytes_o = ADDR_W'(1) << shift_tbl[size_code_i];
      end
   end
endmodule

// File: rtl/smm_seg_range.sv
module smm_seg_range #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ADDR_W-1:0] tolm_i,
   input  logic [ADDR_W-1:0] seg_bytes_i,
   input  logic              size_ok_i,
   output logic              fits_o,
   output logic              in_seg_o
);
   logic [ADDR_W-1:0] base;

   always_comb begin
      fits_o   = size_ok_i && (tolm_i >= seg_bytes_i);
      base     = tolm_i - seg_bytes_i;
      in_seg_o = fits_o && (addr_i >= base) && (addr_i < tolm_i);
   end
endmodule

// File: rtl/smm_route.sv
module smm_route #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [1:0]         src_i,
   input  logic               smm_i,
   input  logic               glob_i,
   input  logic               high_i,
   input  logic               seg_en_i,
   input  logic               open_i,
   input  logic               vga_i,
   input  logic               illegal_i,
   input  logic               seg_fits_i,
   input  logic               in_seg_i,
   input  logic [ADDR_W-1:0]  tolm_i,
   output smm_dec_pkg::dest_e dest_o,
   output logic [ADDR_W-1:0]  dram_o
);
   import smm_dec_pkg::*;

   localparam logic [ADDR_W-1:0] L_LO = ADDR_W'(LEGACY_LO);
   localparam logic [ADDR_W-1:0] L_HI = ADDR_W'(LEGACY_HI);
   localparam logic [ADDR_W-1:0] U_LO = ADDR_W'(UPPER_LO);
   localparam logic [ADDR_W-1:0] U_HI = ADDR_W'(UPPER_HI);

   logic in_leg, in_up, leg_on, up_on, seg_on, may_grant;

   always_comb begin
      in_leg    = (addr_i >= L_LO) && (addr_i <= L_HI);
      in_up     = (addr_i >= U_LO) && (addr_i <= U_HI);
      leg_on    = glob_i & ~high_i;
      up_on     = glob_i & high_i;
      seg_on    = glob_i & seg_en_i & seg_fits_i;
      may_grant = (src_i == SRC_CPU) & (smm_i | open_i) & ~illegal_i;

      dest_o = DEST_IOL;
      dram_o = '0;
      if (may_grant && in_leg && leg_on) begin
         dest_o = DEST_DRAM;
         dram_o = addr_i;
      end else if (may_grant && in_up && up_on) begin
         dest_o = DEST_DRAM;
         dram_o = addr_i - U_LO + L_LO;
      end else if (may_grant && in_seg_i && seg_on) begin
         dest_o = DEST_DRAM;
         dram_o = addr_i;
      end else if (in_leg) begin
         dest_o = vga_i ? DEST_GFX : DEST_IOL;
      end else if (in_up || (in_seg_i && seg_on)) begin
         dest_o = DEST_IOL;
      end else if (addr_i < tolm_i) begin
         dest_o = DEST_DRAM;
         dram_o = addr_i;
      end
   end
endmodule

// File: rtl/smm_window_decoder.sv
module smm_window_decoder #(
   parameter int ADDR_W        = 32,
   parameter int SEG_UNIT_LOG2 = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_src,
   input  logic              smm_mode,
   input  logic              cfg_glob_en,
   input  logic              cfg_high_en,
   input  logic              cfg_seg_en,
   input  logic [1:0]        cfg_seg_size,
   input  logic              cfg_open,
   input  logic              cfg_close,
   input  logic              cfg_vga_en,
   input  logic [ADDR_W-1:0] tolm,
   output logic              rsp_valid,
   output logic [1:0]        rsp_dest,
   output logic [ADDR_W-1:0] rsp_dram_addr,
   output logic              cfg_err
);
   import smm_dec_pkg::*;

   generate
      if (ADDR_W < 32) begin : g_bad_width
         $error("ADDR_W must cover the 32-bit window map");
      end
      if (SEG_UNIT_LOG2 + 3 >= ADDR_W) begin : g_bad_unit
         $error("segment sizes must fit inside ADDR_W");
      end
   endgenerate

   logic              illegal, size_ok, seg_fits, in_seg;
   logic [ADDR_W-1:0] seg_bytes, dram_d;
   dest_e             dest_d, dest_q;

   smm_cfg_check #(.ADDR_W(ADDR_W), .SEG_UNIT_LOG2(SEG_UNIT_LOG2)) u_cfg (
      .open_i      (cfg_open),
      .close_i     (cfg_close),
      .size_code_i (cfg_seg_size),
      .illegal_o   (illegal),
      .size_ok_o   (size_ok),
      .seg_bytes_o (seg_bytes)
   );

   smm_seg_range #(.ADDR_W(ADDR_W)) u_seg (
      .addr_i      (req_addr),
      .tolm_i      (tolm),
      .seg_bytes_i (seg_bytes),
      .size_ok_i   (size_ok),
      .fits_o      (seg_fits),
      .in_seg_o    (in_seg)
   );

   smm_route #(.ADDR_W(ADDR_W)) u_route (
      .addr_i     (req_addr),
      .src_i      (req_src),
      .smm_i      (smm_mode),
      .glob_i     (cfg_glob_en),
      .high_i     (cfg_high_en),
      .seg_en_i   (cfg_seg_en),
      .open_i     (cfg_open),
      .vga_i      (cfg_vga_en),
      .illegal_i  (illegal),
      .seg_fits_i (seg_fits),
      .in_seg_i   (in_seg),
      .tolm_i     (tolm),
      .dest_o     (dest_d),
      .dram_o     (dram_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         dest_q        <= DEST_DRAM;
         rsp_dram_addr <= '0;
         cfg_err       <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         cfg_err   <= illegal;
         if (req_valid) begin
            dest_q        <= dest_d;
            rsp_dram_addr <= dram_d;
         end
      end
   end

   assign rsp_dest = dest_q;
endmodule

// File: rtl/smm_window_decoder_chk.sv
module smm_window_decoder_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_src,
   input logic              cfg_glob_en,
   input logic              cfg_open,
   input logic              cfg_close,
   input logic              rsp_valid,
   input logic [1:0]        rsp_dest,
   input logic [ADDR_W-1:0] rsp_dram_addr,
   input logic              cfg_err
);
   localparam logic [ADDR_W-1:0] U_LO = ADDR_W'(32'hFEDA_0000);
   localparam logic [ADDR_W-1:0] U_HI = ADDR_W'(32'hFEDB_FFFF);
   localparam logic [ADDR_W-1:0] L_LO = ADDR_W'(32'h000A_0000);
   localparam logic [ADDR_W-1:0] L_HI = ADDR_W'(32'h000B_FFFF);

   logic hit_up, hit_any;
   assign hit_up  = (req_addr >= U_LO) && (req_addr <= U_HI);
   assign hit_any = hit_up || ((req_addr >= L_LO) && (req_addr <= L_HI));

   // R1
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R1
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R4
   global_off_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !cfg_glob_en && hit_up) |=> (rsp_dest != 2'd0));

   // R8
   foreign_src_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_src != 2'd0 && hit_any) |=> (rsp_dest != 2'd0));

   // R9
   open_close_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && cfg_close) |=> cfg_err);

   // R9
   err_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cfg_open && cfg_close && hit_any) |=> (rsp_dest != 2'd0));

   // R11
   addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_dest != 2'd0) |-> (rsp_dram_addr == '0));
endmodule

bind smm_window_decoder smm_window_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_addr      (req_addr),
   .req_src       (req_src),
   .cfg_glob_en   (cfg_glob_en),
   .cfg_open      (cfg_open),
   .cfg_close     (cfg_close),
   .rsp_valid     (rsp_valid),
   .rsp_dest      (rsp_dest),
   .rsp_dram_addr (rsp_dram_addr),
   .cfg_err       (cfg_err)
);

// File: tb/sim_smm_window_decoder.sv
module sim_smm_window_decoder;
   localparam int AW = 32;
   localparam logic [1:0] D_DRAM = 2'd0, D_GFX = 2'd1, D_IOL = 2'd2;
   localparam logic [1:0] S_CPU = 2'd0, S_GFX = 2'd1, S_IOL = 2'd2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [1:0] req_src = S_CPU;
   logic smm_mode = 1'b0, cfg_glob_en = 1'b0, cfg_high_en = 1'b0, cfg_seg_en = 1'b0;
   logic [1:0] cfg_seg_size = 2'b00;
   logic cfg_open = 1'b0, cfg_close = 1'b0, cfg_vga_en = 1'b0;
   logic [AW-1:0] tolm = 32'h4000_0000;
   logic rsp_valid, cfg_err;
   logic [1:0] rsp_dest;
   logic [AW-1:0] rsp_dram_addr;

   int n_tests = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   smm_window_decoder u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_src(req_src), .smm_mode(smm_mode), .cfg_glob_en(cfg_glob_en),
      .cfg_high_en(cfg_high_en), .cfg_seg_en(cfg_seg_en), .cfg_seg_size(cfg_seg_size),
      .cfg_open(cfg_open), .cfg_close(cfg_close), .cfg_vga_en(cfg_vga_en), .tolm(tolm),
      .rsp_valid(rsp_valid), .rsp_dest(rsp_dest), .rsp_dram_addr(rsp_dram_addr),
      .cfg_err(cfg_err)
   );

   task automatic chk_bit(input string req, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic set_cfg(input logic g, input logic h, input logic s, input logic [1:0] sz,
                          input logic op, input logic cl, input logic vga, input logic smm);
      @(negedge clk);
      cfg_glob_en = g; cfg_high_en = h; cfg_seg_en = s; cfg_seg_size = sz;
      cfg_open = op; cfg_close = cl; cfg_vga_en = vga; smm_mode = smm;
   endtask

   task automatic xact(input string req, input logic [1:0] src, input logic [AW-1:0] a,
                       input logic [1:0] exp_d, input logic [AW-1:0] exp_a);
      @(negedge clk);
      req_valid = 1'b1; req_src = src; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      n_tests++;
      if (rsp_valid !== 1'b1 || rsp_dest !== exp_d || rsp_dram_addr !== exp_a) begin
         n_fail++;
         $display("FAIL %s addr %h: got v=%0b d=%0d a=%h expected v=1 d=%0d a=%h",
                  req, a, rsp_valid, rsp_dest, rsp_dram_addr, exp_d, exp_a);
      end
      @(negedge clk);
      chk_bit("R1 idle", rsp_valid, 1'b0);
   endtask

   task automatic t_reset();
      chk_bit("R1 reset valid", rsp_valid, 1'b0);
      chk_bit("R1 reset err", cfg_err, 1'b0);
      n_tests++;
      if (rsp_dest !== 2'd0 || rsp_dram_addr !== '0) begin
         n_fail++;
         $display("FAIL R1 reset: got d=%0d a=%h expected 0 0", rsp_dest, rsp_dram_addr);
      end
   endtask

   task automatic t_legacy();
      set_cfg(1, 0, 0, 2'b00, 0, 0, 1, 1);
      xact("R2 low edge", S_CPU, 32'h000A_0000, D_DRAM, 32'h000A_0000);
      xact("R2 high edge", S_CPU, 32'h000B_FFFF, D_DRAM, 32'h000B_FFFF);
      set_cfg(1, 0, 0, 2'b00, 0, 0, 1, 0);
      xact("R6 R7 no smm to gfx", S_CPU, 32'h000A_8000, D_GFX, 0);
      set_cfg(1, 0, 0, 2'b00, 0, 0, 0, 0);
      xact("R7 no smm to iolink", S_CPU, 32'h000A_8000, D_IOL, 0);
      set_cfg(1, 0, 0, 2'b00, 1, 0, 0, 0);
      xact("R6 open grants", S_CPU, 32'h000B_0000, D_DRAM, 32'h000B_0000);
   endtask

   task automatic t_upper();
      set_cfg(1, 1, 0, 2'b00, 0, 0, 1, 1);
      xact("R3 remap", S_CPU, 32'hFEDA_1234, D_DRAM, 32'h000A_1234);
      xact("R3 remap top", S_CPU, 32'hFEDB_FFFF, D_DRAM, 32'h000B_FFFF);
      xact("R3 R7 legacy off", S_CPU, 32'h000A_0000, D_GFX, 0);
      xact("R10 past upper", S_CPU, 32'hFEDC_0000, D_IOL, 0);
      set_cfg(1, 1, 0, 2'b00, 0, 0, 1, 0);
      xact("R10 upper denied", S_CPU, 32'hFEDA_0000, D_IOL, 0);
   endtask

   task automatic t_global_off();
      set_cfg(0, 1, 1, 2'b00, 0, 0, 0, 1);
      xact("R4 upper", S_CPU, 32'hFEDA_0000, D_IOL, 0);
      xact("R4 legacy", S_CPU, 32'h000A_0000, D_IOL, 0);
      set_cfg(0, 1, 1, 2'b00, 0, 0, 0, 0);
      xact("R4 R10 seg plain dram", S_CPU, 32'h3FF0_0000, D_DRAM, 32'h3FF0_0000);
   endtask

   task automatic t_segment();
      set_cfg(1, 0, 1, 2'b00, 0, 0, 0, 1);
      xact("R5 1M grant", S_CPU, 32'h3FF0_0000, D_DRAM, 32'h3FF0_0000);
      set_cfg(1, 0, 1, 2'b00, 0, 0, 0, 0);
      xact("R5 1M denied", S_CPU, 32'h3FF0_0000, D_IOL, 0);
      xact("R5 1M below base", S_CPU, 32'h3FEF_FFFF, D_DRAM, 32'h3FEF_FFFF);
      xact("R10 at tolm", S_CPU, 32'h4000_0000, D_IOL, 0);
      set_cfg(1, 0, 1, 2'b01, 0, 0, 0, 0);
      xact("R5 2M base", S_CPU, 32'h3FE0_0000, D_IOL, 0);
      xact("R5 2M below", S_CPU, 32'h3FDF_FFFF, D_DRAM, 32'h3FDF_FFFF);
      set_cfg(1, 0, 1, 2'b10, 0, 0, 0, 0);
      xact("R5 8M base", S_CPU, 32'h3F80_0000, D_IOL, 0);
      xact("R5 8M below", S_CPU, 32'h3F7F_FFFF, D_DRAM, 32'h3F7F_FFFF);
      @(negedge clk); tolm = 32'h0040_0000;
      xact("R5 tolm below size", S_CPU, 32'h0000_0000, D_DRAM, 32'h0000_0000);
      @(negedge clk); tolm = 32'h4000_0000;
   endtask

   task automatic t_foreign();
      set_cfg(1, 0, 1, 2'b00, 1, 0, 1, 1);
      xact("R8 gfx legacy", S_GFX, 32'h000A_0000, D_GFX, 0);
      xact("R8 iolink seg", S_IOL, 32'h3FF8_0000, D_IOL, 0);
      xact("R8 src 11 seg", 2'd3, 32'h3FF8_0000, D_IOL, 0);
      set_cfg(1, 1, 0, 2'b00, 1, 0, 1, 1);
      xact("R8 iolink upper", S_IOL, 32'hFEDA_0000, D_IOL, 0);
   endtask

   task automatic t_err();
      set_cfg(1, 0, 0, 2'b00, 1, 1, 0, 1);
      @(negedge clk);
      chk_bit("R9 open+close err", cfg_err, 1'b1);
      xact("R9 deny on err", S_CPU, 32'h000A_0000, D_IOL, 0);
      set_cfg(1, 0, 0, 2'b11, 0, 0, 0, 1);
      @(negedge clk);
      chk_bit("R9 rsvd size err", cfg_err, 1'b1);
      xact("R9 legacy deny rsvd", S_CPU, 32'h000A_0000, D_IOL, 0);
      set_cfg(1, 0, 0, 2'b00, 0, 0, 0, 1);
      @(negedge clk);
      chk_bit("R9 err clears", cfg_err, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_legacy();
      t_upper();
      t_global_off();
      t_segment();
      t_foreign();
      t_err();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule